// File: doc/BRIEF.md
# Serial port register and interrupt front end

This block is the software-facing side of a serial port. A word-wide bus slave exposes seven registers: status, data, baud, three control words and a guard-time word. Whole characters arrive from an external serializer on a valid/ready byte interface and leave through a one-cycle transmit strobe. Bit timing, parity and framing are handled by that serializer. One level-sensitive interrupt line tells the processor that a received character is waiting.

A character is taken only while the receive-full flag is clear and the port and its receiver are both enabled. The character then sits in the data register until software reads it. That read clears the flag and drops the interrupt. Status writes follow a split rule. A small value overwrites the status word, with the transmit-empty flag held high. A large value acts as an AND mask that can only clear bits. A data write below a limit sends its low byte and marks transmission complete.

Register reads are combinational from the current state while the read strobe is high. All side effects of a read or a write take place at the clock edge that ends the strobe cycle.

Top module: `serport_regs`

## Requirements
- R1: After reset, status reads 0x0000_00C0, and the data, baud, control 1, control 2, control 3 and guard-time registers read 0. The interrupt is low and `rx_ready` is high.
- R2: With control 1 bits 13 (port enable) and 2 (receiver enable) both set, a character offered while `rx_ready` is high is stored. The next data read returns it, and status bit 5 (receive full) is set.
- R3: If either of those two control bits is clear, an offered character is dropped. The status and the data register are unchanged, and `rx_ready` stays high.
- R4: `rx_ready` is low while status bit 5 is set. A character offered then is not taken, and the data register keeps the earlier character.
- R5: Storing a character raises the interrupt in the next cycle when control 1 bit 5 (receive interrupt enable) is set.
- R6: A data register read (offset 0x04) returns the stored character zero-extended in the low 10 bits. At the same edge it clears status bit 5 and drops the interrupt.
- R7: A status write (offset 0x00) of a value up to 0x3FF loads that value into status with bit 7 (transmit empty) forced to 1.
- R8: A status write of a value above 0x3FF replaces status with status AND value.
- R9: After any status write, the interrupt is low if status bit 5 is clear. If bit 5 is still set, the interrupt keeps its level.
- R10: A data write of a value below 0xF000 pulses `tx_valid` for one cycle in the next cycle, with `tx_data` equal to the value's low byte, and sets status bit 6 (transmission complete). A value of 0xF000 or more produces no pulse and no status change.
- R11: A control 1 write (offset 0x0C) stores the value. If the value has bit 5 set while status bit 5 is already set, the interrupt rises in the next cycle.
- R12: Baud (0x08), control 2 (0x10), control 3 (0x14), guard time (0x18) and control 1 are plain 32-bit read/write storage. Any other offset reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte offset of the register accessed |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_rd is high, 0 otherwise |
| rx_valid | input | 1 | Serializer offers a received character |
| rx_data | input | CHAR_W | Received character |
| rx_ready | output | 1 | Block can take a character |
| tx_valid | output | 1 | One-cycle strobe: send tx_data |
| tx_data | output | 8 | Character to send |
| irq | output | 1 | Level interrupt: received character pending |

## Verification
The bench pushes the status write rule to its boundaries. It writes 0x3FF and 0x400, and it masks with values that clear the transmit-empty flag. A design that compared against the wrong limit would overwrite where it should mask, or the reverse, and the status readback would show it. It offers characters with each enable missing and while the receive-full flag is set. A design that gated on only one enable, or ignored the hold-off, would replace the data register contents. It also covers the transmit limit at 0xEFFF and 0xF000, a status write that leaves the receive flag set (the interrupt must stay high), and enabling the interrupt after a character is already pending (the interrupt must fire at once rather than wait for the next character).

// File: rtl/serport_pkg.sv
package serport_pkg;

    localparam int REG_W     = 32;
    localparam int REG_BYTES = REG_W / 8;
    localparam int NUM_REGS  = 7;
    localparam int NUM_CFG   = 5;
    localparam int ST_W      = 10;
    localparam int RD_DATA_W = 10;
    localparam int TX_W      = 8;

    // register index = byte offset / REG_BYTES
    localparam int IDX_STAT  = 0;
    localparam int IDX_DATA  = 1;
    localparam int IDX_BAUD  = 2;
    localparam int IDX_CTL1  = 3;
    localparam int IDX_CTL2  = 4;
    localparam int IDX_CTL3  = 5;
    localparam int IDX_GUARD = 6;
    localparam int CFG_BASE  = IDX_BAUD;

    // status flags
    localparam int ST_RXFULL  = 5;
    localparam int ST_TXDONE  = 6;
    localparam int ST_TXEMPTY = 7;
    localparam logic [ST_W-1:0] ST_RESET = ST_W'(10'h0C0);

    // control 1 bits
    localparam int C1_RXEN = 2;
    localparam int C1_RXIE = 5;
    localparam int C1_EN   = 13;

    localparam logic [REG_W-1:0] ST_LOAD_MAX = 32'h0000_03FF;
    localparam logic [REG_W-1:0] TX_LIMIT    = 32'h0000_F000;
    localparam logic [REG_W-1:0] RD_MASK     = REG_W'((64'd1 << RD_DATA_W) - 1);

    typedef struct packed {
        logic [REG_W-1:0]    wdata;
        logic [NUM_REGS-1:0] rd;
        logic [NUM_REGS-1:0] wr;
    } bus_req_t;

    function automatic logic [ST_W-1:0] status_write(
        input logic [ST_W-1:0]  cur,
        input logic [REG_W-1:0] val
    );
        logic [ST_W-1:0] res;
        if (val <= ST_LOAD_MAX) begin
            res = val[ST_W-1:0];
            res[ST_TXEMPTY] = 1'b1;
        end else begin
            res = cur & val[ST_W-1:0];
        end
        return res;
    endfunction

endpackage

// File: rtl/ser_addr_dec.sv
module ser_addr_dec
    import serport_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic             rd,
    input  logic             wr,
    input  logic [REG_W-1:0] wdata,
    output bus_req_t         req
);

    logic [NUM_REGS-1:0] hit;

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_hit
        assign hit[i] = (addr == ADDR_W'(i * REG_BYTES));
    end

    always_comb begin
        req.wdata = wdata;
        req.rd    = rd ? hit : '0;
        req.wr    = wr ? hit : '0;
    end

    // R12: an access reaches at most one register
    p_one_target_r12: assert property (@(posedge clk) disable iff (rst)
        $onehot0(req.wr) && $onehot0(req.rd));

endmodule

// File: rtl/ser_cfg_bank.sv
module ser_cfg_bank
    import serport_pkg::*;
#(
    parameter int N = NUM_CFG
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [N-1:0]             wr,
    input  logic [REG_W-1:0]         wdata,
    output logic [N-1:0][REG_W-1:0]  cfg_q
);

    for (genvar i = 0; i < N; i++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst) begin
                cfg_q[i] <= '0;
            end else if (wr[i]) begin
                cfg_q[i] <= wdata;
            end
        end

        // R12: storage holds its value when not written
        p_hold_r12: assert property (@(posedge clk) disable iff (rst)
            !wr[i] |=> $stable(cfg_q[i]));
    end

endmodule

// File: rtl/ser_stat_path.sv
module ser_stat_path
    import serport_pkg::*;
#(
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              st_wr,
    input  logic              dt_wr,
    input  logic              dt_rd,
    input  logic [REG_W-1:0]  wdata,
    input  logic              rx_valid,
    input  logic [CHAR_W-1:0] rx_data,
    input  logic              rx_on,
    output logic              rx_ready,
    output logic              rx_set,
    output logic [ST_W-1:0]   sr_q,
    output logic              rxne_next,
    output logic [CHAR_W-1:0] data_q,
    output logic              tx_valid,
    output logic [TX_W-1:0]   tx_data
);

    logic [ST_W-1:0]   sr_n;
    logic [CHAR_W-1:0] data_n;
    logic              rx_take;
    logic              tx_go;

    assign rx_ready = !sr_q[ST_RXFULL];
    assign rx_take  = rx_valid && rx_ready;
    assign rx_set   = rx_take && rx_on;
    assign tx_go    = dt_wr && (wdata < TX_LIMIT);

    always_comb begin
        sr_n   = sr_q;
        data_n = data_q;
        if (st_wr) begin
            sr_n = status_write(sr_q, wdata);
        end
        if (tx_go) begin
            sr_n[ST_TXDONE] = 1'b1;
        end
        if (dt_rd) begin
            sr_n[ST_RXFULL] = 1'b0;
        end
        if (rx_set) begin
            sr_n[ST_RXFULL] = 1'b1;
            data_n          = rx_data;
        end
    end

    assign rxne_next = sr_n[ST_RXFULL];

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q     <= ST_RESET;
            data_q   <= '0;
            tx_valid <= 1'b0;
            tx_data  <= '0;
        end else begin
            sr_q     <= sr_n;
            data_q   <= data_n;
            tx_valid <= tx_go;
            if (tx_go) begin
                tx_data <= wdata[TX_W-1:0];
            end
        end
    end

    // R2: an accepted character lands in the data register with the flag set
    p_accept_r2: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && rx_ready && rx_on) |=> (sr_q[ST_RXFULL] && data_q == $past(rx_data)));

    // R3: a disabled receiver leaves the data register alone
    p_drop_r3: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && rx_ready && !rx_on) |=> $stable(data_q));

    // R4: no character is taken while one is pending
    p_hold_off_r4: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && !rx_ready) |=> $stable(data_q));

    // R10: out-of-range data writes send nothing
    p_tx_filter_r10: assert property (@(posedge clk) disable iff (rst)
        (dt_wr && wdata >= TX_LIMIT) |=> !tx_valid);

    // R10: a send is always accompanied by transmission complete
    p_tc_r10: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> sr_q[ST_TXDONE]);

endmodule

// File: rtl/ser_irq_gen.sv
module ser_irq_gen (
    input  logic clk,
    input  logic rst,
    input  logic st_wr,
    input  logic dt_rd,
    input  logic c1_wr,
    input  logic c1_wr_ie,
    input  logic c1_ie,
    input  logic rxne_now,
    input  logic rxne_next,
    input  logic rx_set,
    output logic irq
);

    logic irq_n;

    always_comb begin
        irq_n = irq;
        if (st_wr && !rxne_next) begin
            irq_n = 1'b0;
        end
        if (dt_rd) begin
            irq_n = 1'b0;
        end
        if (c1_wr && c1_wr_ie && rxne_now) begin
            irq_n = 1'b1;
        end
        if (rx_set && c1_ie) begin
            irq_n = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq <= 1'b0;
        end else begin
            irq <= irq_n;
        end
    end

    // R5: storing a character with the interrupt enabled raises the line
    p_accept_irq_r5: assert property (@(posedge clk) disable iff (rst)
        (rx_set && c1_ie) |=> irq);

    // R6: a data read with no new character drops the line
    p_read_clear_r6: assert property (@(posedge clk) disable iff (rst)
        (dt_rd && !rx_set) |=> !irq);

    // R9: after a status write the line is low unless the flag survived
    p_stwr_clear_r9: assert property (@(posedge clk) disable iff (rst)
        st_wr |=> (rxne_now || !irq));

    // R11: enabling the interrupt with data pending fires at once
    p_ctl1_fire_r11: assert property (@(posedge clk) disable iff (rst)
        (c1_wr && c1_wr_ie && rxne_now) |=> irq);

endmodule

// File: rtl/serport_regs.sv
module serport_regs
    import serport_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              rx_valid,
    input  logic [CHAR_W-1:0] rx_data,
    output logic              rx_ready,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              irq
);

    bus_req_t                       req;
    logic [NUM_CFG-1:0][REG_W-1:0]  cfg_q;
    logic [NUM_REGS-1:0][REG_W-1:0] view;
    logic [ST_W-1:0]                sr_q;
    logic [CHAR_W-1:0]              data_q;
    logic                           rxne_next;
    logic                           rx_set;
    logic                           rx_on;
    logic [REG_W-1:0]               ctl1;

    ser_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
        .clk   (clk),
        .rst   (rst),
        .addr  (bus_addr),
        .rd    (bus_rd),
        .wr    (bus_wr),
        .wdata (bus_wdata),
        .req   (req)
    );

    ser_cfg_bank #(.N(NUM_CFG)) u_cfg (
        .clk   (clk),
        .rst   (rst),
        .wr    (req.wr[CFG_BASE +: NUM_CFG]),
        .wdata (req.wdata),
        .cfg_q (cfg_q)
    );

    assign ctl1  = cfg_q[IDX_CTL1 - CFG_BASE];
    assign rx_on = ctl1[C1_EN] && ctl1[C1_RXEN];

    ser_stat_path #(.CHAR_W(CHAR_W)) u_stat (
        .clk       (clk),
        .rst       (rst),
        .st_wr     (req.wr[IDX_STAT]),
        .dt_wr     (req.wr[IDX_DATA]),
        .dt_rd     (req.rd[IDX_DATA]),
        .wdata     (req.wdata),
        .rx_valid  (rx_valid),
        .rx_data   (rx_data),
        .rx_on     (rx_on),
        .rx_ready  (rx_ready),
        .rx_set    (rx_set),
        .sr_q      (sr_q),
        .rxne_next (rxne_next),
        .data_q    (data_q),
        .tx_valid  (tx_valid),
        .tx_data   (tx_data)
    );

    ser_irq_gen u_irq (
        .clk       (clk),
        .rst       (rst),
        .st_wr     (req.wr[IDX_STAT]),
        .dt_rd     (req.rd[IDX_DATA]),
        .c1_wr     (req.wr[IDX_CTL1]),
        .c1_wr_ie  (req.wdata[C1_RXIE]),
        .c1_ie     (ctl1[C1_RXIE]),
        .rxne_now  (sr_q[ST_RXFULL]),
        .rxne_next (rxne_next),
        .rx_set    (rx_set),
        .irq       (irq)
    );

    // register view for the read mux
    assign view[IDX_STAT] = REG_W'(sr_q);
    assign view[IDX_DATA] = REG_W'(data_q) & RD_MASK;
    for (genvar i = 0; i < NUM_CFG; i++) begin : g_view
        assign view[CFG_BASE + i] = cfg_q[i];
    end

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (req.rd[i]) begin
                bus_rdata = bus_rdata | view[i];
            end
        end
    end

endmodule

// File: tb/tb_serport_regs.sv
module tb_serport_regs;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_ready;
    logic        tx_valid;
    logic [7:0]  tx_data;
    logic        irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    serport_regs dut (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .rx_valid  (rx_valid),
        .rx_data   (rx_data),
        .rx_ready  (rx_ready),
        .tx_valid  (tx_valid),
        .tx_data   (tx_data),
        .irq       (irq)
    );

    typedef struct packed {
        logic        is_rd;
        logic [7:0]  addr;
        logic [31:0] data;
        logic [31:0] expv;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 23;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 8'h08, 32'h0001_2345, 32'h0,          4'd12}, // R12 baud
        '{1'b1, 8'h08, 32'h0,         32'h0001_2345, 4'd12},
        '{1'b0, 8'h10, 32'hFFFF_FFFF, 32'h0,          4'd12}, // R12 ctl2
        '{1'b1, 8'h10, 32'h0,         32'hFFFF_FFFF, 4'd12},
        '{1'b0, 8'h14, 32'hA5A5_5A5A, 32'h0,          4'd12}, // R12 ctl3
        '{1'b1, 8'h14, 32'h0,         32'hA5A5_5A5A, 4'd12},
        '{1'b0, 8'h18, 32'h0000_00FF, 32'h0,          4'd12}, // R12 guard
        '{1'b1, 8'h18, 32'h0,         32'h0000_00FF, 4'd12},
        '{1'b0, 8'h1C, 32'h0000_DEAD, 32'h0,          4'd12}, // R12 undefined
        '{1'b1, 8'h1C, 32'h0,         32'h0,          4'd12},
        '{1'b1, 8'h08, 32'h0,         32'h0001_2345, 4'd12},
        '{1'b0, 8'h00, 32'h0000_0003, 32'h0,          4'd7},  // R7 load
        '{1'b1, 8'h00, 32'h0,         32'h0000_0083, 4'd7},
        '{1'b0, 8'h00, 32'h0000_0000, 32'h0,          4'd7},
        '{1'b1, 8'h00, 32'h0,         32'h0000_0080, 4'd7},
        '{1'b0, 8'h00, 32'h0000_03FF, 32'h0,          4'd7},  // R7 upper limit
        '{1'b1, 8'h00, 32'h0,         32'h0000_03FF, 4'd7},
        '{1'b0, 8'h00, 32'hFFFF_FFDF, 32'h0,          4'd8},  // R8 mask
        '{1'b1, 8'h00, 32'h0,         32'h0000_03DF, 4'd8},
        '{1'b0, 8'h00, 32'h0000_0400, 32'h0,          4'd8},  // R8 first masking value
        '{1'b1, 8'h00, 32'h0,         32'h0000_0000, 4'd8},
        '{1'b0, 8'h00, 32'h0000_0000, 32'h0,          4'd7},
        '{1'b1, 8'h00, 32'h0,         32'h0000_0080, 4'd7}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, expv);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
        #1;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        bus_rd   = 1'b1;
        #1;
        d = bus_rdata;
        @(negedge clk);
        bus_rd   = 1'b0;
        #1;
    endtask

    task automatic rx_send(input logic [7:0] c);
        @(negedge clk);
        rx_valid = 1'b1;
        rx_data  = c;
        @(negedge clk);
        rx_valid = 1'b0;
        #1;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
    endtask

    task automatic reset_checks();
        logic [31:0] v;
        chk("R1 irq", {31'b0, irq}, 32'h0);
        chk("R1 rx_ready", {31'b0, rx_ready}, 32'h1);
        bus_read(8'h00, v); chk("R1 status", v, 32'h0000_00C0);
        bus_read(8'h04, v); chk("R1 data", v, 32'h0);
        bus_read(8'h08, v); chk("R1 baud", v, 32'h0);
        bus_read(8'h0C, v); chk("R1 ctl1", v, 32'h0);
        bus_read(8'h10, v); chk("R1 ctl2", v, 32'h0);
        bus_read(8'h14, v); chk("R1 ctl3", v, 32'h0);
        bus_read(8'h18, v); chk("R1 guard", v, 32'h0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        do_reset();
        reset_checks();

        // vector table: plain storage and status write rule
        for (int i = 0; i < NV; i++) begin
            if (VECS[i].is_rd) begin
                bus_read(VECS[i].addr, v);
                checks++;
                if (v !== VECS[i].expv) begin
                    failures++;
                    $display("FAIL R%0d vector %0d actual=0x%08h expected=0x%08h",
                             VECS[i].req, i, v, VECS[i].expv);
                end
            end else begin
                bus_write(VECS[i].addr, VECS[i].data);
            end
        end

        // R3: receiver disabled in three ways
        rx_send(8'h55);
        chk("R3 ready with all off", {31'b0, rx_ready}, 32'h1);
        bus_read(8'h00, v); chk("R3 status all off", v, 32'h0000_0080);
        bus_write(8'h0C, 32'h0000_2000);
        rx_send(8'h66);
        bus_read(8'h00, v); chk("R3 status port only", v, 32'h0000_0080);
        bus_read(8'h0C, v); chk("R12 ctl1 readback", v, 32'h0000_2000);
        bus_write(8'h0C, 32'h0000_0004);
        rx_send(8'h77);
        bus_read(8'h00, v); chk("R3 status receiver only", v, 32'h0000_0080);
        bus_read(8'h04, v); chk("R3 data untouched", v, 32'h0);

        // R10: transmit path and its limit
        bus_write(8'h04, 32'h0000_01A7);
        chk("R10 tx_valid pulse", {31'b0, tx_valid}, 32'h1);
        chk("R10 tx_data low byte", {24'b0, tx_data}, 32'h0000_00A7);
        @(negedge clk); #1;
        chk("R10 tx_valid single cycle", {31'b0, tx_valid}, 32'h0);
        bus_read(8'h00, v); chk("R10 tc set", v, 32'h0000_00C0);
        bus_write(8'h00, 32'h0);
        bus_write(8'h04, 32'h0000_F000);
        chk("R10 no pulse at limit", {31'b0, tx_valid}, 32'h0);
        bus_read(8'h00, v); chk("R10 status unchanged at limit", v, 32'h0000_0080);
        bus_write(8'h04, 32'h0000_EFFF);
        chk("R10 pulse below limit", {31'b0, tx_valid}, 32'h1);
        chk("R10 data below limit", {24'b0, tx_data}, 32'h0000_00FF);
        bus_read(8'h00, v); chk("R10 tc below limit", v, 32'h0000_00C0);

        // R2 / R5: accept with interrupt enabled
        bus_write(8'h0C, 32'h0000_2024);
        rx_send(8'h3C);
        chk("R5 irq on accept", {31'b0, irq}, 32'h1);
        chk("R4 ready low when full", {31'b0, rx_ready}, 32'h0);
        bus_read(8'h00, v); chk("R2 status full", v, 32'h0000_00E0);
        chk("R2 status read keeps irq", {31'b0, irq}, 32'h1);

        // R4: second character held off
        rx_send(8'h99);
        bus_read(8'h04, v); chk("R4 first char kept", v, 32'h0000_003C);
        chk("R6 irq dropped by read", {31'b0, irq}, 32'h0);
        chk("R6 ready after read", {31'b0, rx_ready}, 32'h1);
        bus_read(8'h00, v); chk("R6 flag cleared", v, 32'h0000_00C0);

        // R9: status writes and the interrupt
        rx_send(8'h11);
        chk("R9 irq before write", {31'b0, irq}, 32'h1);
        bus_write(8'h00, 32'hFFFF_FFFF);
        chk("R9 irq kept when flag survives", {31'b0, irq}, 32'h1);
        bus_write(8'h00, 32'hFFFF_FFDF);
        chk("R9 irq dropped when flag cleared", {31'b0, irq}, 32'h0);
        bus_read(8'h00, v); chk("R9 status after mask", v, 32'h0000_00C0);
        bus_read(8'h04, v); chk("R6 data after flag cleared", v, 32'h0000_0011);

        // R11: late interrupt enable
        bus_write(8'h0C, 32'h0000_2004);
        rx_send(8'h22);
        chk("R11 no irq while disabled", {31'b0, irq}, 32'h0);
        chk("R2 ready low with irq off", {31'b0, rx_ready}, 32'h0);
        bus_write(8'h0C, 32'h0000_2024);
        chk("R11 irq on enable", {31'b0, irq}, 32'h1);
        bus_read(8'h04, v); chk("R11 data", v, 32'h0000_0022);
        chk("R6 irq cleared", {31'b0, irq}, 32'h0);

        // R1: reset again from a busy state
        rx_send(8'h44);
        do_reset();
        reset_checks();

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule